// File: doc/BRIEF.md
# DDR2 Write Burst Data Launcher

This block sits on the controller side of a DDR2-style memory interface and produces the outgoing write data path. A write command arrives with a burst length of four or eight elements and the read-latency setting currently programmed into the memory. The block derives the write latency from that setting. It then pulls data beats from a valid/ready source and lays out the strobe and the data on a double-rate timeline.

Each clock is modelled as two half-cycle slots. The strobe sits high in the first half of a data cycle and low in the second. The data bus therefore carries one element on the rising strobe edge and one on the falling edge. Every source beat holds two data elements and their byte masks.

Before the first data cycle, the strobe is driven low with the bus enabled. After the last data cycle, it is held low again, and then the bus is released. Commands spaced exactly one burst apart produce a continuous data stream.

Top module: `ddr2w_launcher`

## Requirements
- R1: The write latency WL equals the read latency minus one, where read latencies below 3 are taken as 3 and those above 6 as 6. For a command in cycle c, the first data cycle is c+WL.
- R2: The cycle before a burst's first data cycle is a preamble when that cycle is not itself a data cycle. In a preamble, bus_oe is 1 and dqs_h is 2'b00.
- R3: In every data cycle, dqs_h is 2'b01 (bit 0 is the first half-slot) and bus_oe is 1. A four-element burst spans two data cycles and an eight-element burst spans four.
- R4: The cycle after a data cycle is a postamble when it is not a data cycle. In a postamble, bus_oe is 1 and dqs_h is 2'b00.
- R5: In a cycle that is neither a data, preamble nor postamble cycle, the bus is released: bus_oe is 0, dqs_h is 2'b00, dq_out is 0 and dm_out is all ones.
- R6: In a data cycle, dq_out and dm_out carry the beat accepted at the end of the previous cycle. The low half of each holds the first-slot element. A mask bit of 1 means that byte is not to be written, and 0 means it is written.
- R7: A second command issued BL/2 cycles after the first makes its data cycles follow the first burst's without a gap. No low strobe cycle appears between the two bursts.
- R8: wd_ready is 1 exactly in the cycle before each data cycle, and a beat is consumed only when wd_ready and wd_valid are both 1.
- R9: If wd_valid is 0 while wd_ready is 1, the following data cycle drives dq_out 0 and dm_out all ones. err then becomes 1 and stays 1 until reset.
- R10: While rst_n is 0 at a clock edge, the outputs take the released state of R5, and err and wd_ready are 0.
- R11: The write latency is captured when a command is accepted. Later changes on cmd_rl do not move that command's data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Write command in this cycle |
| cmd_bl8 | input | 1 | 1: eight-element burst, 0: four-element burst |
| cmd_rl | input | 3 | Read-latency setting, legal 3 to 6 |
| wd_valid | input | 1 | Source beat available |
| wd_ready | output | 1 | Beat taken at the end of this cycle |
| wd_data | input | 2*DQ_W | Two data elements, low half first |
| wd_mask | input | 2*DQ_W/8 | Byte masks for the two elements, 1 = skip byte |
| dq_out | output | 2*DQ_W | Data driven in the two half-slots |
| dm_out | output | 2*DQ_W/8 | Byte masks driven in the two half-slots |
| dqs_h | output | 2 | Strobe level per half-slot, bit 0 first |
| bus_oe | output | 1 | Output enable for data, mask and strobe |
| err | output | 1 | Sticky data underflow flag |

## Verification
The postamble of one burst and the preamble of the next can fall in the same cycle when a second command leaves exactly one idle cycle between the two data windows. A seamless pair removes that cycle altogether. The bench provokes both by spacing commands BL/2 and BL/2+1 cycles apart. Its reference model knows only which absolute cycles carry data, and from that it expects an enabled low strobe in the shared cycle and an unbroken 2'b01 strobe run in the seamless case. A starved source inside a running burst is also made to coincide with a data cycle. That case is judged on the masked output and on the sticky flag.

// File: rtl/ddr2w_pkg.sv
// Shared definitions for the DDR2 write launcher.
// Assumes a double-rate model with two half-cycle slots per clock.
package ddr2w_pkg;
    // Data cycles per burst length: each clock carries two elements.
    localparam int BL4_CYC = 2;
    localparam int BL8_CYC = 4;

    // Output phase of the next cycle.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PRE  = 2'd1,
        PH_DATA = 2'd2,
        PH_POST = 2'd3
    } phase_e;
endpackage

// File: rtl/ddr2w_wl_calc.sv
// Write latency calculator.
// Clamps the read-latency setting into [RL_MIN, RL_MAX] and subtracts one clock.
// Assumes RL_MIN >= 3, so that the result is never below 2.
module ddr2w_wl_calc #(
    parameter int RL_W   = 3,
    parameter int RL_MIN = 3,
    parameter int RL_MAX = 6
) (
    input  logic [RL_W-1:0] rl,
    output logic [RL_W-1:0] wl
);
    // Clamp, then apply the one-cycle offset.
    always_comb begin
        if (int'(rl) < RL_MIN)
            wl = RL_W'(RL_MIN - 1);
        else if (int'(rl) > RL_MAX)
            wl = RL_W'(RL_MAX - 1);
        else
            wl = rl - 1'b1;
    end
endmodule

// File: rtl/ddr2w_sched.sv
// Data-cycle scheduler.
// Keeps a bitmap of upcoming data cycles: bit j of the register marks the
// cycle j clocks after the current one. A command sets BL/2 bits, starting
// at offset WL-1 from the next cycle. Assumes WL >= 2, so a command never
// marks the cycle that immediately follows it. Overlapping commands simply
// merge their bits.
module ddr2w_sched
    import ddr2w_pkg::*;
#(
    parameter int SCH_W = 9,
    parameter int WL_W  = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  logic            cmd_bl8,
    input  logic [WL_W-1:0] wl,
    output logic            data_now,
    output logic            data_next,
    output logic            pre_next
);
    logic [SCH_W-1:0] sched_q;
    logic [SCH_W-1:0] sched_d;
    logic [SCH_W-1:0] fill;

    // Bits to set for an accepted command.
    always_comb begin
        fill = '0;
        for (int j = 0; j < SCH_W; j++) begin
            if (cmd_valid && (j >= int'(wl) - 1) &&
                (j < int'(wl) - 1 + (cmd_bl8 ? BL8_CYC : BL4_CYC)))
                fill[j] = 1'b1;
        end
    end

    assign sched_d = (sched_q >> 1) | fill;

    // Advance the bitmap by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sched_q <= '0;
        else
            sched_q <= sched_d;
    end

    assign data_now  = sched_q[0];
    assign data_next = sched_q[1];
    assign pre_next  = sched_d[1] & ~sched_q[1];
endmodule

// File: rtl/ddr2w_out.sv
// Output stage.
// Registers the strobe, data, mask and enable for the next cycle from the
// scheduler's view of that cycle. Accepts a source beat exactly when the
// next cycle is a data cycle. Assumes a preamble and a postamble landing in
// the same cycle drive the same levels.
module ddr2w_out
    import ddr2w_pkg::*;
#(
    parameter int DQ_W  = 16,
    parameter int MSK_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               data_now,
    input  logic               data_next,
    input  logic               pre_next,
    input  logic               wd_valid,
    input  logic [2*DQ_W-1:0]  wd_data,
    input  logic [2*MSK_W-1:0] wd_mask,
    output logic [2*DQ_W-1:0]  dq_out,
    output logic [2*MSK_W-1:0] dm_out,
    output logic [1:0]         dqs_h,
    output logic               bus_oe,
    output logic               err
);
    phase_e phase_d;

    // Classify the next cycle.
    always_comb begin
        if (data_next)
            phase_d = PH_DATA;
        else if (pre_next)
            phase_d = PH_PRE;
        else if (data_now)
            phase_d = PH_POST;
        else
            phase_d = PH_IDLE;
    end

    // Register the strobe, enable and data lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dq_out <= '0;
            dm_out <= '1;
            dqs_h  <= 2'b00;
            bus_oe <= 1'b0;
        end else begin
            bus_oe <= (phase_d != PH_IDLE);
            dqs_h  <= (phase_d == PH_DATA) ? 2'b01 : 2'b00;
            if (phase_d == PH_DATA && wd_valid) begin
                dq_out <= wd_data;
                dm_out <= wd_mask;
            end else begin
                dq_out <= '0;
                dm_out <= '1;
            end
        end
    end

    // Sticky underflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err <= 1'b0;
        else if (data_next && !wd_valid)
            err <= 1'b1;
    end
endmodule

// File: rtl/ddr2w_launcher.sv
// DDR2 write burst data launcher (top).
// Turns write commands into a double-rate strobe and data stream with
// preamble, postamble and seamless back-to-back bursts. Assumes that the
// source supplies two elements per beat and that commands arrive no closer
// than BL/2 cycles apart.
module ddr2w_launcher #(
    parameter  int DQ_W   = 16,
    parameter  int RL_W   = 3,
    parameter  int RL_MIN = 3,
    parameter  int RL_MAX = 6,
    localparam int MSK_W  = DQ_W / 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               cmd_bl8,
    input  logic [RL_W-1:0]    cmd_rl,
    input  logic               wd_valid,
    output logic               wd_ready,
    input  logic [2*DQ_W-1:0]  wd_data,
    input  logic [2*MSK_W-1:0] wd_mask,
    output logic [2*DQ_W-1:0]  dq_out,
    output logic [2*MSK_W-1:0] dm_out,
    output logic [1:0]         dqs_h,
    output logic               bus_oe,
    output logic               err
);
    localparam int SCH_W = RL_MAX - 1 + ddr2w_pkg::BL8_CYC;

    logic [RL_W-1:0] wl;
    logic            data_now;
    logic            data_next;
    logic            pre_next;

    ddr2w_wl_calc #(.RL_W(RL_W), .RL_MIN(RL_MIN), .RL_MAX(RL_MAX)) wl_i (
        .rl (cmd_rl),
        .wl (wl)
    );

    ddr2w_sched #(.SCH_W(SCH_W), .WL_W(RL_W)) sched_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_bl8   (cmd_bl8),
        .wl        (wl),
        .data_now  (data_now),
        .data_next (data_next),
        .pre_next  (pre_next)
    );

    ddr2w_out #(.DQ_W(DQ_W), .MSK_W(MSK_W)) out_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_now  (data_now),
        .data_next (data_next),
        .pre_next  (pre_next),
        .wd_valid  (wd_valid),
        .wd_data   (wd_data),
        .wd_mask   (wd_mask),
        .dq_out    (dq_out),
        .dm_out    (dm_out),
        .dqs_h     (dqs_h),
        .bus_oe    (bus_oe),
        .err       (err)
    );

    // A beat is taken when the coming cycle carries data.
    assign wd_ready = data_next;
endmodule

// File: rtl/ddr2w_launcher_chk.sv
// Protocol checker for ddr2w_launcher, attached with bind.
// Watches only the top-level ports.
module ddr2w_launcher_chk #(
    parameter int MSK_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wd_valid,
    input logic               wd_ready,
    input logic [1:0]         dqs_h,
    input logic               bus_oe,
    input logic [2*MSK_W-1:0] dm_out,
    input logic               err
);
    AST_READY_LEADS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        wd_ready |=> (dqs_h == 2'b01)); // R8

    AST_STROBE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_h != 2'b00) |-> (bus_oe && dqs_h == 2'b01)); // R3

    AST_PREAMBLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        (dqs_h == 2'b01 && $past(dqs_h) != 2'b01) |-> $past(bus_oe)); // R2

    AST_POSTAMBLE_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dqs_h) == 2'b01 && dqs_h != 2'b01) |-> bus_oe); // R4

    AST_IDLE_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> (dm_out == '1)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err); // R9

    AST_ERR_ON_STARVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_ready && !wd_valid) |=> err); // R9
endmodule

bind ddr2w_launcher ddr2w_launcher_chk #(.MSK_W(MSK_W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wd_valid (wd_valid),
    .wd_ready (wd_ready),
    .dqs_h    (dqs_h),
    .bus_oe   (bus_oe),
    .dm_out   (dm_out),
    .err      (err)
);

// File: tb/ddr2w_launcher_tb_top.sv
// Cycle-by-cycle reference bench for ddr2w_launcher.
module ddr2w_launcher_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DQ_W  = 16;
    localparam int MSK_W = DQ_W / 8;
    localparam int BEAT_W = 2 * DQ_W + 2 * MSK_W;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               cmd_valid = 1'b0;
    logic               cmd_bl8 = 1'b0;
    logic [2:0]         cmd_rl = 3'd3;
    logic               wd_valid = 1'b0;
    logic               wd_ready;
    logic [2*DQ_W-1:0]  wd_data = '0;
    logic [2*MSK_W-1:0] wd_mask = '0;
    logic [2*DQ_W-1:0]  dq_out;
    logic [2*MSK_W-1:0] dm_out;
    logic [1:0]         dqs_h;
    logic               bus_oe;
    logic               err;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ddr2w_launcher dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_bl8(cmd_bl8),
        .cmd_rl(cmd_rl), .wd_valid(wd_valid), .wd_ready(wd_ready),
        .wd_data(wd_data), .wd_mask(wd_mask), .dq_out(dq_out), .dm_out(dm_out),
        .dqs_h(dqs_h), .bus_oe(bus_oe), .err(err)
    );

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int word_seq = 0;
    bit dmap[int];
    bit bstart[int];
    logic [BEAT_W-1:0] src[$];
    logic [BEAT_W-1:0] beat = '0;
    bit beat_ok = 1'b0;
    bit err_m = 1'b0;
    string scen = "reset";

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp, string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s (%s) cycle %0d: actual %h expected %h",
                     req, what, scen, cyc, act, exp);
        end
    endtask

    function automatic int wl_of(int r);
        if (r < 3) return 2;
        if (r > 6) return 5;
        return r - 1;
    endfunction

    task automatic refill();
        while (src.size() < 4) begin
            logic [2*DQ_W-1:0]  d;
            logic [2*MSK_W-1:0] m;
            d = 32'(word_seq) * 32'h0001_0003 + 32'h1234_5678;
            m = 4'(word_seq * 3 + 1);
            src.push_back({m, d});
            word_seq++;
        end
    endtask

    // One clock: check this cycle's outputs, drive inputs, update model.
    task automatic step(bit cv, bit bl8, int r, bit starve);
        bit d, pre, post;
        string tag;
        @(negedge clk);
        d    = dmap.exists(cyc);
        pre  = !d && dmap.exists(cyc + 1);
        post = !d && dmap.exists(cyc - 1);
        if (d) tag = bstart.exists(cyc) ? (dmap.exists(cyc - 1) ? "R7" : "R1") : "R3";
        else if (pre) tag = "R2";
        else if (post) tag = "R4";
        else tag = "R5";
        chk(tag, 64'(bus_oe), 64'(d | pre | post), "bus_oe");
        chk(tag, 64'(dqs_h), d ? 64'd1 : 64'd0, "dqs_h");
        chk(d ? "R6" : tag, 64'(dq_out),
            (d && beat_ok) ? 64'(beat[2*DQ_W-1:0]) : 64'd0, "dq_out");
        chk(d ? "R6" : tag, 64'(dm_out),
            (d && beat_ok) ? 64'(beat[BEAT_W-1:2*DQ_W]) : 64'(4'hF), "dm_out");
        chk("R8", 64'(wd_ready), 64'(dmap.exists(cyc + 1)), "wd_ready");
        chk("R9", 64'(err), 64'(err_m), "err");
        refill();
        cmd_valid = cv;
        cmd_bl8   = bl8;
        cmd_rl    = 3'(r);
        wd_valid  = !starve;
        wd_data   = src[0][2*DQ_W-1:0];
        wd_mask   = src[0][BEAT_W-1:2*DQ_W];
        beat_ok = 1'b0;
        if (dmap.exists(cyc + 1)) begin
            if (!starve) begin
                beat = src.pop_front();
                beat_ok = 1'b1;
            end else begin
                err_m = 1'b1;
            end
        end
        if (cv) begin
            int wl;
            wl = wl_of(r);
            bstart[cyc + wl] = 1'b1;
            for (int i = 0; i < (bl8 ? 4 : 2); i++) dmap[cyc + wl + i] = 1'b1;
        end
        cyc++;
    endtask

    task automatic idle(int n, int r);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, r, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: state held in reset
        chk("R10", 64'(bus_oe), 64'd0, "bus_oe in reset");
        chk("R10", 64'(dqs_h), 64'd0, "dqs_h in reset");
        chk("R10", 64'(dm_out), 64'(4'hF), "dm_out in reset");
        chk("R10", 64'(err), 64'd0, "err in reset");
        chk("R10", 64'(wd_ready), 64'd0, "wd_ready in reset");
        rst_n = 1'b1;

        scen = "R1 BL4 rl3";
        step(1, 0, 3, 0); idle(8, 5);
        scen = "R1 BL8 rl6";
        step(1, 1, 6, 0); idle(10, 2);
        scen = "R1 clamp rl7";
        step(1, 0, 7, 0); idle(9, 4);
        scen = "R1 clamp rl1";
        step(1, 0, 1, 0); idle(6, 6);
        scen = "R11 rl moves after accept";
        step(1, 1, 4, 0); idle(3, 6); idle(6, 3);
        scen = "R7 BL4 back to back";
        step(1, 0, 5, 0); idle(1, 5); step(1, 0, 5, 0); idle(10, 5);
        scen = "R7 BL8 chain";
        step(1, 1, 3, 0); idle(3, 3); step(1, 1, 3, 0); idle(3, 3);
        step(1, 0, 3, 0); idle(10, 3);
        scen = "R2 R4 one-cycle gap";
        step(1, 0, 4, 0); idle(2, 4); step(1, 0, 4, 0); idle(10, 4);
        scen = "R9 starved beat";
        step(1, 1, 3, 0); idle(1, 3); step(0, 0, 3, 1); idle(10, 3);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog expired at cycle %0d", cyc);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule